// File: doc/BRIEF.md
# Idle and Standby Handshake Controller

This block is the power-management agent of a processing subsystem. An external power manager asks it to go idle over a request/acknowledge pair. The block answers that request and drives a standby status output. It follows two 2-bit policy fields held in a small bus-writable register file. Each field selects one of four policies:

- forced: answer at once
- never: do not answer at all
- smart: answer only when quiet
- smart with wakeup: as smart, and the block may also raise a wakeup request

Four activity inputs report whether each internal source is busy: the core, two DMA engines and the bus initiator. Each input is sampled into a status register. The block is quiet when every status bit reads idle.

While the idle handshake is complete in the wakeup-capable smart policy, the block can raise a wakeup request. Only an external interrupt input or a DMA event whose own enable bit is set can do this. The wakeup is held until the power manager withdraws its idle request.

Top module: `pwr_handshake_ctrl`

## Requirements
- R1: After reset, idle_ack, standby and wake_req are 0. The policy register reads 0xA (both policies smart). All four enable words read 0. The status register reads 0xF (all sources active).
- R2: The register map is word-addressed. Address 0 holds the idle policy in bits [1:0] and the standby policy in bits [3:2]; bits [31:4] read 0. Addresses 1 and 2 hold interrupt enables 31..0 and 63..32. Addresses 3 and 4 hold DMA event enables 31..0 and 63..32. A write to any of these addresses takes effect at the next clock edge, and each reads back exactly what was stored. The policy code is 0 forced, 1 never, 2 smart, 3 smart with wakeup.
- R3: In the forced idle policy, idle_ack rises in the cycle after idle_req is sampled high, whatever the activity status.
- R4: In the never idle policy, idle_ack stays 0 however long idle_req is held.
- R5: In the smart policies (2 and 3), idle_ack rises only in the cycle after a cycle in which idle_req was high and every status bit was 0. Once acknowledged, idle_ack stays high while idle_req stays high, even if a source becomes active again.
- R6: One cycle after idle_req is sampled low, idle_ack is 0.
- R7: wake_req rises one cycle after an enabled wake source is seen while idle_ack is high and the idle policy is 3. It then holds until idle_req is sampled low or the policy leaves 3. Policies 0, 1 and 2 never raise it.
- R8: An interrupt input or DMA event whose enable bit is 0 never causes a wakeup. Both the 64 interrupt inputs and the 64 DMA events can wake the block.
- R9: standby is registered from the standby policy in effect one cycle earlier: forced gives 1; never gives 0; smart and smart with wakeup give 1 exactly when the status register reads 0.
- R10: Address 5 is the status register, with 1 = active. Bit 0 is the core, bit 1 is DMA engine 0, bit 2 is DMA engine 1 and bit 3 is the bus initiator. It loads the activity inputs every cycle, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| core_busy | input | 1 | Core activity, 1 = active |
| dma0_busy | input | 1 | DMA engine 0 activity |
| dma1_busy | input | 1 | DMA engine 1 activity |
| init_busy | input | 1 | Bus initiator activity |
| idle_req | input | 1 | Idle request from the power manager |
| irq_in | input | 64 | External interrupt inputs |
| dma_evt | input | 64 | DMA event inputs |
| idle_ack | output | 1 | Idle acknowledge |
| standby | output | 1 | Standby status |
| wake_req | output | 1 | Wakeup request |

## Verification
Register writes and activity inputs change the internal state at the next edge. idle_ack, standby and wake_req are registered, so each responds one edge after its inputs. A change in activity therefore reaches a smart acknowledge or smart standby only on the second edge: one edge to load the status register, one for the output. The bench drives inputs on the falling edge and samples outputs on the following falling edge. After each edge it moves its expected state forward by one step, and it reads the register file a short delay after setting the address. The directed cases count out the two-edge paths explicitly; the random phase compares all three outputs in every cycle.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;
  localparam int REG_W = 32;
  localparam int SRC_N = 4;

  typedef enum logic [1:0] {
    PM_FORCE      = 2'd0,
    PM_NEVER      = 2'd1,
    PM_SMART      = 2'd2,
    PM_SMART_WAKE = 2'd3
  } pm_mode_e;

  localparam logic [3:0] MODE_RESET = 4'hA;
endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_hs_pkg::*;
#(
  parameter int IRQ_W  = 64,
  parameter int DMA_W  = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [SRC_N-1:0]  act_in,
  output logic [REG_W-1:0]  reg_rdata,
  output pm_mode_e          idle_mode,
  output pm_mode_e          stby_mode,
  output logic [IRQ_W-1:0]  irq_en,
  output logic [DMA_W-1:0]  dma_en,
  output logic [SRC_N-1:0]  act_q
);
  localparam int IRQ_WORDS = IRQ_W / REG_W;
  localparam int DMA_WORDS = DMA_W / REG_W;
  localparam int IRQ_BASE  = 1;
  localparam int DMA_BASE  = IRQ_BASE + IRQ_WORDS;
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DMA_BASE + DMA_WORDS);

  logic [3:0]       mode_q, mode_d;
  logic             mode_we;
  logic [SRC_N-1:0] act_d;

  // Policy register
  assign mode_we = reg_wr && (reg_addr == MODE_ADDR);
  always_comb mode_d = mode_we ? reg_wdata[3:0] : mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode_d;
  end
  assign idle_mode = pm_mode_e'(mode_q[1:0]);
  assign stby_mode = pm_mode_e'(mode_q[3:2]);

  // Interrupt wake enable words
  for (genvar gi = 0; gi < IRQ_WORDS; gi++) begin : g_irq_word
    logic [REG_W-1:0] word_q, word_d;
    logic             we;
    assign we = reg_wr && (reg_addr == ADDR_W'(IRQ_BASE + gi));
    always_comb word_d = we ? reg_wdata : word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign irq_en[gi*REG_W +: REG_W] = word_q;
  end

  // DMA event wake enable words
  for (genvar gd = 0; gd < DMA_WORDS; gd++) begin : g_dma_word
    logic [REG_W-1:0] word_q, word_d;
    logic             we;
    assign we = reg_wr && (reg_addr == ADDR_W'(DMA_BASE + gd));
    always_comb word_d = we ? reg_wdata : word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign dma_en[gd*REG_W +: REG_W] = word_q;
  end

  // Activity status, loaded every cycle
  always_comb act_d = act_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '1;
    else        act_q <= act_d;
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == MODE_ADDR) reg_rdata[3:0] = mode_q;
    for (int i = 0; i < IRQ_WORDS; i++)
      if (reg_addr == ADDR_W'(IRQ_BASE + i)) reg_rdata = irq_en[i*REG_W +: REG_W];
    for (int j = 0; j < DMA_WORDS; j++)
      if (reg_addr == ADDR_W'(DMA_BASE + j)) reg_rdata = dma_en[j*REG_W +: REG_W];
    if (reg_addr == STAT_ADDR) reg_rdata[SRC_N-1:0] = act_q;
  end

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(reg_wdata[3:0]))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(irq_en) && $stable(dma_en))); // R2
  AST_STAT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (act_q == $past(act_in))); // R10
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_hs_pkg::*;
#(
  parameter int IRQ_W = 64,
  parameter int DMA_W = 64
) (
  input  logic [IRQ_W-1:0] irq_in,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [DMA_W-1:0] dma_in,
  input  logic [DMA_W-1:0] dma_en,
  output logic             wake_hit
);
  localparam int IRQ_WORDS = IRQ_W / REG_W;
  localparam int DMA_WORDS = DMA_W / REG_W;
  localparam int LANES     = IRQ_WORDS + DMA_WORDS;

  logic [LANES-1:0] lane_hit;

  for (genvar gi = 0; gi < IRQ_WORDS; gi++) begin : g_irq_lane
    assign lane_hit[gi] = |(irq_in[gi*REG_W +: REG_W] & irq_en[gi*REG_W +: REG_W]);
  end
  for (genvar gd = 0; gd < DMA_WORDS; gd++) begin : g_dma_lane
    assign lane_hit[IRQ_WORDS+gd] = |(dma_in[gd*REG_W +: REG_W] & dma_en[gd*REG_W +: REG_W]);
  end

  assign wake_hit = |lane_hit;
endmodule

// File: rtl/pwr_idle_fsm.sv
module pwr_idle_fsm
  import pwr_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     idle_req,
  input  pm_mode_e idle_mode,
  input  pm_mode_e stby_mode,
  input  logic     quiet,
  input  logic     wake_hit,
  output logic     idle_ack,
  output logic     standby,
  output logic     wake_req
);
  logic ack_q, ack_d;
  logic stby_q, stby_d;
  logic wake_q, wake_d;

  always_comb begin
    ack_d = 1'b0;
    if (idle_req) begin
      case (idle_mode)
        PM_FORCE: ack_d = 1'b1;
        PM_NEVER: ack_d = 1'b0;
        default:  ack_d = ack_q | quiet;
      endcase
    end
  end

  always_comb begin
    case (stby_mode)
      PM_FORCE: stby_d = 1'b1;
      PM_NEVER: stby_d = 1'b0;
      default:  stby_d = quiet;
    endcase
  end

  always_comb begin
    wake_d = 1'b0;
    if (idle_req && (idle_mode == PM_SMART_WAKE))
      wake_d = wake_q | (ack_q & wake_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      stby_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      stby_q <= stby_d;
      wake_q <= wake_d;
    end
  end

  assign idle_ack = ack_q;
  assign standby  = stby_q;
  assign wake_req = wake_q;

  AST_FORCE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && idle_mode == PM_FORCE) |=> idle_ack); // R3
  AST_NEVER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode == PM_NEVER) |=> !idle_ack); // R4
  AST_SMART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode inside {PM_SMART, PM_SMART_WAKE} && !idle_ack && !quiet) |=> !idle_ack); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_req |=> !idle_ack); // R6
  AST_WAKE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode != PM_SMART_WAKE) |=> !wake_req); // R7
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && idle_req && idle_mode == PM_SMART_WAKE) |=> wake_req); // R7
  AST_STBY_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_mode == PM_NEVER) |=> !standby); // R9
  AST_STBY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_mode == PM_FORCE) |=> standby); // R9
endmodule

// File: rtl/pwr_handshake_ctrl.sv
module pwr_handshake_ctrl
  import pwr_hs_pkg::*;
#(
  parameter int IRQ_W  = 64,
  parameter int DMA_W  = 64,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              core_busy,
  input  logic              dma0_busy,
  input  logic              dma1_busy,
  input  logic              init_busy,
  input  logic              idle_req,
  input  logic [IRQ_W-1:0]  irq_in,
  input  logic [DMA_W-1:0]  dma_evt,
  output logic              idle_ack,
  output logic              standby,
  output logic              wake_req
);
  pm_mode_e         idle_mode, stby_mode;
  logic [IRQ_W-1:0] irq_en;
  logic [DMA_W-1:0] dma_en;
  logic [SRC_N-1:0] act_in, act_q;
  logic             quiet, wake_hit;

  assign act_in = {init_busy, dma1_busy, dma0_busy, core_busy};
  assign quiet  = ~|act_q;

  pwr_cfg_regs #(.IRQ_W(IRQ_W), .DMA_W(DMA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .act_in(act_in), .reg_rdata(reg_rdata),
    .idle_mode(idle_mode), .stby_mode(stby_mode), .irq_en(irq_en),
    .dma_en(dma_en), .act_q(act_q)
  );

  pwr_wake_detect #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) u_wake (
    .irq_in(irq_in), .irq_en(irq_en), .dma_in(dma_evt), .dma_en(dma_en),
    .wake_hit(wake_hit)
  );

  pwr_idle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_mode(idle_mode),
    .stby_mode(stby_mode), .quiet(quiet), .wake_hit(wake_hit),
    .idle_ack(idle_ack), .standby(standby), .wake_req(wake_req)
  );

  AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_hit && !wake_req) |=> !wake_req); // R8
  AST_SMART_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_mode inside {PM_SMART, PM_SMART_WAKE} && !quiet) |=> !standby); // R9
endmodule

// File: tb/tb_pwr_handshake_ctrl.sv
module tb_pwr_handshake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        core_busy, dma0_busy, dma1_busy, init_busy, idle_req;
  logic [63:0] irq_in, dma_evt;
  logic        idle_ack, standby, wake_req;

  int checks = 0;
  int errors = 0;

  logic [1:0]  m_im, m_sm;
  logic [3:0]  m_act;
  logic        m_ack, m_stby, m_wake;
  logic [63:0] m_ien, m_den;

  always #5 clk = ~clk;

  pwr_handshake_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_busy(core_busy),
    .dma0_busy(dma0_busy), .dma1_busy(dma1_busy), .init_busy(init_busy),
    .idle_req(idle_req), .irq_in(irq_in), .dma_evt(dma_evt),
    .idle_ack(idle_ack), .standby(standby), .wake_req(wake_req)
  );

  function automatic logic f_ack(logic req, logic [1:0] m, logic ack, logic q);
    return req && (m == 2'd0 || (m[1] && (ack || q)));
  endfunction
  function automatic logic f_stby(logic [1:0] m, logic q);
    return (m == 2'd0) || (m[1] && q);
  endfunction
  function automatic logic f_wake(logic req, logic [1:0] m, logic w, logic ack, logic hit);
    return req && (m == 2'd3) && (w || (ack && hit));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_busy(logic [3:0] b);
    {init_busy, dma1_busy, dma0_busy, core_busy} = b;
  endtask

  task automatic step();
    logic q, hit, n_ack, n_stby, n_wake;
    q      = (m_act == 4'd0);
    hit    = |(irq_in & m_ien) || |(dma_evt & m_den);
    n_ack  = f_ack(idle_req, m_im, m_ack, q);
    n_stby = f_stby(m_sm, q);
    n_wake = f_wake(idle_req, m_im, m_wake, m_ack, hit);
    @(posedge clk);
    @(negedge clk);
    m_ack  = n_ack;
    m_stby = n_stby;
    m_wake = n_wake;
    m_act  = {init_busy, dma1_busy, dma0_busy, core_busy};
    if (reg_wr) begin
      case (reg_addr)
        3'd0: {m_sm, m_im} = reg_wdata[3:0];
        3'd1: m_ien[31:0]  = reg_wdata;
        3'd2: m_ien[63:32] = reg_wdata;
        3'd3: m_den[31:0]  = reg_wdata;
        3'd4: m_den[63:32] = reg_wdata;
        default: ;
      endcase
    end
    chk("R5 model idle_ack", {31'd0, idle_ack}, {31'd0, m_ack});
    chk("R9 model standby", {31'd0, standby}, {31'd0, m_stby});
    chk("R7 model wake_req", {31'd0, wake_req}, {31'd0, m_wake});
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_busy(4'hF); idle_req = 1'b0; irq_in = '0; dma_evt = '0;
    m_im = 2'd2; m_sm = 2'd2; m_act = 4'hF; m_ack = 0; m_stby = 0; m_wake = 0;
    m_ien = '0; m_den = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 idle_ack", {31'd0, idle_ack}, 0);
    chk("R1 standby", {31'd0, standby}, 0);
    chk("R1 wake_req", {31'd0, wake_req}, 0);
    rd("R1 policy", 3'd0, 32'hA);
    for (int i = 1; i < 5; i++) rd("R1 enables", 3'(i), 32'h0);
    rd("R1 status", 3'd5, 32'hF);

    // R2 register map
    wr(3'd0, 32'hFFFF_FFF0);
    rd("R2 policy upper bits", 3'd0, 32'h0);
    wr(3'd0, 32'h0000_000A);
    rd("R2 policy", 3'd0, 32'hA);
    wr(3'd1, 32'hDEAD_BEEF); wr(3'd2, 32'h0BAD_F00D);
    wr(3'd3, 32'h1234_5678); wr(3'd4, 32'h8765_4321);
    rd("R2 irq lo", 3'd1, 32'hDEAD_BEEF);
    rd("R2 irq hi", 3'd2, 32'h0BAD_F00D);
    rd("R2 dma lo", 3'd3, 32'h1234_5678);
    rd("R2 dma hi", 3'd4, 32'h8765_4321);

    // R10 status register
    wr(3'd5, 32'h0);
    rd("R10 write ignored", 3'd5, 32'hF);
    set_busy(4'hE); step();
    rd("R10 core idle", 3'd5, 32'hE);
    set_busy(4'h1); step();
    rd("R10 core only", 3'd5, 32'h1);
    set_busy(4'hF); step();

    // R5 smart idle, then R6 release
    idle_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R5 busy no ack", {31'd0, idle_ack}, 0);
    end
    set_busy(4'h0); step();
    chk("R5 status loading", {31'd0, idle_ack}, 0);
    step(); chk("R5 quiet ack", {31'd0, idle_ack}, 1);
    set_busy(4'h1); step();
    chk("R5 ack held", {31'd0, idle_ack}, 1);
    idle_req = 1'b0; step();
    chk("R6 ack release", {31'd0, idle_ack}, 0);

    // R3 forced idle
    set_busy(4'hF);
    wr(3'd0, 32'h8);
    idle_req = 1'b1; step();
    chk("R3 force ack", {31'd0, idle_ack}, 1);
    idle_req = 1'b0; step();
    chk("R6 force release", {31'd0, idle_ack}, 0);

    // R4 never idle
    wr(3'd0, 32'h9);
    set_busy(4'h0);
    idle_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(); chk("R4 never ack", {31'd0, idle_ack}, 0);
    end
    idle_req = 1'b0; step();

    // R9 standby policies
    set_busy(4'hF); step();
    wr(3'd0, 32'h2); step();
    chk("R9 force standby", {31'd0, standby}, 1);
    wr(3'd0, 32'h6); step();
    chk("R9 never standby", {31'd0, standby}, 0);
    wr(3'd0, 32'hA); step();
    chk("R9 smart busy", {31'd0, standby}, 0);
    set_busy(4'h0); step(); step();
    chk("R9 smart quiet", {31'd0, standby}, 1);
    wr(3'd0, 32'hE); step();
    chk("R9 smart wake quiet", {31'd0, standby}, 1);

    // R7 / R8 wakeup
    wr(3'd0, 32'hB);
    wr(3'd1, 32'h0); wr(3'd2, 32'h0000_0200); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    idle_req = 1'b1; step(); step();
    chk("R7 acked", {31'd0, idle_ack}, 1);
    irq_in[40] = 1'b1; step(); irq_in = '0;
    chk("R8 masked irq", {31'd0, wake_req}, 0);
    step(); chk("R8 masked irq later", {31'd0, wake_req}, 0);
    irq_in[41] = 1'b1; step(); irq_in = '0;
    chk("R7 wake raised", {31'd0, wake_req}, 1);
    step(); chk("R7 wake held", {31'd0, wake_req}, 1);
    idle_req = 1'b0; step();
    chk("R7 wake drop", {31'd0, wake_req}, 0);
    wr(3'd3, 32'h20);
    idle_req = 1'b1; step(); step();
    dma_evt[5] = 1'b1; step(); dma_evt = '0;
    chk("R8 dma wake", {31'd0, wake_req}, 1);
    idle_req = 1'b0; step();
    wr(3'd0, 32'hA);
    idle_req = 1'b1; step(); step();
    irq_in[41] = 1'b1; step();
    chk("R7 smart no wake", {31'd0, wake_req}, 0);
    step(); irq_in = '0;
    chk("R7 smart no wake later", {31'd0, wake_req}, 0);
    idle_req = 1'b0; step();

    // Random phase
    wr(3'd1, $urandom()); wr(3'd2, $urandom());
    wr(3'd3, $urandom() & 32'h0F0F_0F0F); wr(3'd4, $urandom() & 32'h00FF_00FF);
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = $urandom();
      end
      if ($urandom_range(0, 3) == 0) set_busy(($urandom_range(0, 2) == 0) ? 4'($urandom()) : 4'h0);
      if ($urandom_range(0, 9) == 0) idle_req = ~idle_req;
      irq_in = '0; dma_evt = '0;
      if ($urandom_range(0, 7) == 0) irq_in[$urandom_range(0, 63)] = 1'b1;
      if ($urandom_range(0, 7) == 0) dma_evt[$urandom_range(0, 63)] = 1'b1;
      step();
      reg_wr = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule